// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This block is a bank of independent down-counting timers reached through a simple register read/write bus. The number of channels is a parameter, either two or four, and each channel drives its own interrupt line. Each channel has a 64-bit counter fed from the bus clock through its own power-of-two prescaler. The counter is loaded from a 64-bit interval register, runs in either auto-reload (periodic) mode or stop-on-expiry (one-shot) mode, and can be read back as two 32-bit words.

Software typically uses one channel, loaded with all-ones in periodic mode, as a free-running falling time base. Another channel serves as an event timer: software disables it, writes a new interval, and re-enables it with the reload bit set. When a channel is disabled it keeps counting for a short fixed window before it halts. Software has to allow for that window before it rewrites the channel.

Top module: `hs_timer_bank`

## Requirements
- R1: After reset every register reads 0 and all interrupt lines are low.
- R2: The interrupt enable register is at 0x00 and the interrupt status register is at 0x04. Channel n places its words at 0x20*n + 0x10 + 4*k, where k=0 is control, k=1 and k=2 are the interval low and high words, and k=3 and k=4 are the count low and high words. Any address outside this map reads 0.
- R3: The control register has these fields: bit 0 is enable, bit 1 is reload request, bits 6:4 are the prescale select and bit 7 is one-shot. The written fields read back at the same positions.
- R4: A control write with bit 1 set copies the interval into the counter on the next clock. After that clock, bit 1 reads back as 0.
- R5: With prescale select p, an enabled channel ticks once every 2^p clocks. The divider restarts when the channel goes from disabled to enabled.
- R6: Each tick lowers the counter by one. A tick that finds the counter at 0 is an expiry, so a loaded value N expires on the (N+1)th tick.
- R7: In periodic mode (bit 7 = 0) an expiry reloads the interval and counting continues.
- R8: In one-shot mode an expiry leaves the counter at 0 and clears the channel's enable bit.
- R9: After a control write clears the enable bit of a running channel, the channel keeps counting for exactly two further clocks and then holds its count.
- R10: An expiry sets status bit n. Writing 1 to status bit n clears it, and writing 0 has no effect. If an expiry and a clear fall in the same cycle, the set wins.
- R11: Interrupt line n is high exactly when status bit n and enable bit n are both set.
- R12: A read strobe on a channel's count-low word latches that channel's high count word. Reads of the count-high word return the latched value, not the live one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used for the count snapshot) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
The main counting function is tried in four settings, each meant to expose a different fault:
- A short periodic interval at prescale 0 fixes the exact expiry cycle and the reload value.
- A one-shot run at prescale 2 checks the divider spacing and the self-clearing enable.
- A prescale-1 run that switches to prescale 0 and is then disabled measures the two-cycle stop window tick by tick.
- A 64-bit interval that borrows across the word boundary separates a latched high-word read from a live one.

A behavioural model in the bench follows every register on every clock. It is compared against the read data and the interrupt lines on every clock, including back-to-back status clears that collide with periodic expiries.

// File: rtl/hstmr_pkg.sv
package hstmr_pkg;
   // Shared register offsets
   localparam int unsigned IE_OFS    = 32'h00;
   localparam int unsigned IS_OFS    = 32'h04;
   localparam int unsigned CH_BASE   = 32'h10;
   localparam int unsigned CH_STRIDE = 32'h20;

   // Per-channel word index (byte offset = 4*index)
   localparam int unsigned NUM_WORDS = 5;
   localparam int unsigned W_CTL     = 0;
   localparam int unsigned W_IVL_LO  = 1;
   localparam int unsigned W_IVL_HI  = 2;
   localparam int unsigned W_CNT_LO  = 3;
   localparam int unsigned W_CNT_HI  = 4;

   // Control field positions
   localparam int unsigned B_EN      = 0;
   localparam int unsigned B_LOAD    = 1;
   localparam int unsigned B_PRE     = 4;
   localparam int unsigned PRE_W     = 3;
   localparam int unsigned B_ONESHOT = 7;

   function automatic int unsigned word_addr(int unsigned ch, int unsigned w);
      return CH_BASE + CH_STRIDE * ch + 4 * w;
   endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int unsigned SEL_W = hstmr_pkg::PRE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int unsigned DIV_W = (1 << SEL_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] lim;
   logic [DIV_W:0]   pow2;

   always_comb begin
      pow2      = '0;
      pow2[sel] = 1'b1;
      lim       = DIV_W'(pow2 - 1'b1);
   end

   assign tick = active && (div_q >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n)                          div_q <= '0;
      else if (restart || !active || tick) div_q <= '0;
      else                                 div_q <= div_q + 1'b1;
   end

   // R5
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && lim != '0) |=> (!tick || lim == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 64,
   parameter int unsigned GRACE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic              ivl_lo_we,
   input  logic              ivl_hi_we,
   input  logic              cnt_lo_re,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctl_rdata,
   output logic [CNT_W-1:0]  ivl_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [DATA_W-1:0] snap_hi,
   output logic              expire
);
   import hstmr_pkg::*;

   localparam int unsigned GR_W = $clog2(GRACE_CYC + 1);

   logic             en_q, pend_q, os_q;
   logic [PRE_W-1:0] pre_q;
   logic [GR_W-1:0]  grace_q;
   logic             active, start, tick;
   logic             unused_bits;

   assign unused_bits = ^{wdata[3:2], wdata[DATA_W-1:8]};
   assign active = en_q || (grace_q != '0);
   assign start  = ctl_we && wdata[B_EN] && !en_q;
   assign expire = tick && !pend_q && (cnt_q == '0);

   tmr_prescaler #(.SEL_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .restart (start),
      .sel     (pre_q),
      .tick    (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         pend_q  <= 1'b0;
         os_q    <= 1'b0;
         pre_q   <= '0;
         grace_q <= '0;
         ivl_q   <= '0;
         cnt_q   <= '0;
         snap_hi <= '0;
      end else begin
         if (ctl_we) begin
            en_q   <= wdata[B_EN];
            pend_q <= wdata[B_LOAD];
            pre_q  <= wdata[B_PRE +: PRE_W];
            os_q   <= wdata[B_ONESHOT];
         end else begin
            pend_q <= 1'b0;
            if (expire && os_q) en_q <= 1'b0;
         end

         if (ctl_we && en_q && !wdata[B_EN]) grace_q <= GR_W'(GRACE_CYC);
         else if (ctl_we && wdata[B_EN])     grace_q <= '0;
         else if (grace_q != '0)             grace_q <= grace_q - 1'b1;

         if (ivl_lo_we) ivl_q[DATA_W-1:0]     <= wdata;
         if (ivl_hi_we) ivl_q[CNT_W-1:DATA_W] <= wdata;

         if (pend_q)              cnt_q <= ivl_q;
         else if (tick) begin
            if (cnt_q == '0)      cnt_q <= os_q ? '0 : ivl_q;
            else                  cnt_q <= cnt_q - 1'b1;
         end

         if (cnt_lo_re) snap_hi <= cnt_q[CNT_W-1:DATA_W];
      end
   end

   always_comb begin
      ctl_rdata                    = '0;
      ctl_rdata[B_EN]              = en_q;
      ctl_rdata[B_LOAD]            = pend_q;
      ctl_rdata[B_PRE +: PRE_W]    = pre_q;
      ctl_rdata[B_ONESHOT]         = os_q;
   end

   // R4
   reload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> (cnt_q == $past(ivl_q)));
   // R6
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !pend_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
   // R7
   periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !os_q) |=> (cnt_q == $past(ivl_q)));
   // R8
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && os_q && !ctl_we) |=> (!en_q && cnt_q == '0));
   // R9
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !pend_q) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [NUM_CH-1:0] ie,
   input  logic [NUM_CH-1:0] status,
   input  logic [NUM_CH-1:0][hstmr_pkg::NUM_WORDS-1:0][DATA_W-1:0] words,
   output logic [DATA_W-1:0] rdata
);
   import hstmr_pkg::*;

   always_comb begin
      rdata = '0;
      if (32'(addr) == IE_OFS) rdata = DATA_W'(ie);
      if (32'(addr) == IS_OFS) rdata = DATA_W'(status);
      for (int n = 0; n < NUM_CH; n++) begin
         for (int k = 0; k < NUM_WORDS; k++) begin
            if (32'(addr) == word_addr(n, k)) rdata = words[n][k];
         end
      end
   end
endmodule

// File: rtl/hs_timer_bank.sv
module hs_timer_bank #(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 64,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned GRACE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] irq
);
   import hstmr_pkg::*;

   localparam int unsigned TOP_ADDR = CH_BASE + CH_STRIDE * NUM_CH;

   if (!(NUM_CH == 2 || NUM_CH == 4)) begin : g_bad_nch
      $error("NUM_CH must be 2 or 4");
   end
   if (CNT_W != 2 * DATA_W) begin : g_bad_cnt
      $error("CNT_W must be twice DATA_W");
   end
   if (TOP_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for channel map");
   end

   logic [NUM_CH-1:0] ie_q, st_q, expire, sw_clr;
   logic [NUM_CH-1:0][NUM_WORDS-1:0][DATA_W-1:0] words;
   logic ie_we;

   assign ie_we = bus_wr && (32'(bus_addr) == IE_OFS);

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic [CNT_W-1:0] ivl, cnt;
      logic [DATA_W-1:0] ctl_rd, snap;

      tmr_channel #(
         .DATA_W    (DATA_W),
         .CNT_W     (CNT_W),
         .GRACE_CYC (GRACE_CYC)
      ) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .ctl_we    (bus_wr && 32'(bus_addr) == word_addr(n, W_CTL)),
         .ivl_lo_we (bus_wr && 32'(bus_addr) == word_addr(n, W_IVL_LO)),
         .ivl_hi_we (bus_wr && 32'(bus_addr) == word_addr(n, W_IVL_HI)),
         .cnt_lo_re (bus_rd && 32'(bus_addr) == word_addr(n, W_CNT_LO)),
         .wdata     (bus_wdata),
         .ctl_rdata (ctl_rd),
         .ivl_q     (ivl),
         .cnt_q     (cnt),
         .snap_hi   (snap),
         .expire    (expire[n])
      );

      assign words[n][W_CTL]    = ctl_rd;
      assign words[n][W_IVL_LO] = ivl[DATA_W-1:0];
      assign words[n][W_IVL_HI] = ivl[CNT_W-1:DATA_W];
      assign words[n][W_CNT_LO] = cnt[DATA_W-1:0];
      assign words[n][W_CNT_HI] = snap;

      assign sw_clr[n] = bus_wr && (32'(bus_addr) == IS_OFS) && bus_wdata[n];

      always_ff @(posedge clk) begin
         if (!rst_n)          st_q[n] <= 1'b0;
         else if (expire[n])  st_q[n] <= 1'b1;
         else if (sw_clr[n])  st_q[n] <= 1'b0;
      end

      // R10
      status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sw_clr[n] && !expire[n]) |=> !st_q[n]);
      // R10
      status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q[n] && !sw_clr[n]) |=> st_q[n]);
      // R10
      status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         expire[n] |=> st_q[n]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     ie_q <= '0;
      else if (ie_we) ie_q <= bus_wdata[NUM_CH-1:0];
   end

   assign irq = st_q & ie_q;

   tmr_rdmux #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_rd (
      .addr   (bus_addr),
      .ie     (ie_q),
      .status (st_q),
      .words  (words),
      .rdata  (bus_rdata)
   );
endmodule

// File: tb/tb_hs_timer_bank.sv
`timescale 1ns/1ps
module tb_hs_timer_bank;
   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] irq;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   hs_timer_bank #(.NUM_CH(NCH)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // behavioural reference state
   bit          m_en[NCH], m_pend[NCH], m_os[NCH];
   int          m_pre[NCH], m_grace[NCH], m_div[NCH];
   logic [63:0] m_cnt[NCH], m_ivl[NCH];
   logic [31:0] m_snap[NCH];
   logic [NCH-1:0] m_ie = '0, m_st = '0;

   function automatic int base(int c); return 16 + 32 * c; endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h @%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      logic [NCH-1:0] nst = m_st;
      for (int c = 0; c < NCH; c++) begin
         bit act = m_en[c] || (m_grace[c] > 0);
         int lim = (1 << m_pre[c]) - 1;
         bit tk  = act && (m_div[c] >= lim);
         bit ex  = tk && !m_pend[c] && (m_cnt[c] == 0);
         bit wc  = bus_wr && bus_addr == 8'(base(c));
         bit st  = wc && bus_wdata[0] && !m_en[c];
         logic [63:0] ncnt = m_cnt[c];
         if (m_pend[c]) ncnt = m_ivl[c];
         else if (tk) ncnt = (m_cnt[c] == 0) ? (m_os[c] ? 64'd0 : m_ivl[c]) : m_cnt[c] - 1;
         if (bus_rd && bus_addr == 8'(base(c) + 12)) m_snap[c] = m_cnt[c][63:32];
         m_div[c] = (st || !act || tk) ? 0 : m_div[c] + 1;
         if (wc && m_en[c] && !bus_wdata[0]) m_grace[c] = 2;
         else if (wc && bus_wdata[0])        m_grace[c] = 0;
         else if (m_grace[c] > 0)            m_grace[c] = m_grace[c] - 1;
         if (wc) begin
            m_en[c] = bus_wdata[0]; m_pend[c] = bus_wdata[1];
            m_pre[c] = int'(bus_wdata[6:4]); m_os[c] = bus_wdata[7];
         end else begin
            m_pend[c] = 0;
            if (ex && m_os[c]) m_en[c] = 0;
         end
         m_cnt[c] = ncnt;
         if (bus_wr && bus_addr == 8'(base(c) + 4)) m_ivl[c][31:0]  = bus_wdata;
         if (bus_wr && bus_addr == 8'(base(c) + 8)) m_ivl[c][63:32] = bus_wdata;
         if (ex) nst[c] = 1'b1;
         else if (bus_wr && bus_addr == 8'h04 && bus_wdata[c]) nst[c] = 1'b0;
      end
      m_st = nst;
      if (bus_wr && bus_addr == 8'h00) m_ie = bus_wdata[NCH-1:0];
   endtask

   function automatic logic [31:0] exp_rd(logic [7:0] a);
      if (a == 8'h00) return 32'(m_ie);
      if (a == 8'h04) return 32'(m_st);
      for (int c = 0; c < NCH; c++) begin
         if (a == 8'(base(c)))      return {24'd0, m_os[c], 3'(m_pre[c]), 2'b00, m_pend[c], m_en[c]};
         if (a == 8'(base(c) + 4))  return m_ivl[c][31:0];
         if (a == 8'(base(c) + 8))  return m_ivl[c][63:32];
         if (a == 8'(base(c) + 12)) return m_cnt[c][31:0];
         if (a == 8'(base(c) + 16)) return m_snap[c];
      end
      return 32'd0;
   endfunction

   task automatic step(bit w, bit r, logic [7:0] a, logic [31:0] d);
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk("R11 irq", 64'(irq), 64'(m_st & m_ie));
      chk("R2 rdata", 64'(bus_rdata), 64'(exp_rd(a)));
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d); step(1, 0, a, d); endtask
   task automatic idle(logic [7:0] a, int n); repeat (n) step(0, 0, a, 0); endtask

   initial begin
      for (int c = 0; c < NCH; c++) begin
         m_en[c] = 0; m_pend[c] = 0; m_os[c] = 0; m_pre[c] = 0;
         m_grace[c] = 0; m_div[c] = 0; m_cnt[c] = 0; m_ivl[c] = 0; m_snap[c] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 irq", 64'(irq), 0);
      chk("R1 ie", 64'(bus_rdata), 0);
      idle(8'h10, 1);
      chk("R1 ctl0", 64'(bus_rdata), 0);

      // periodic channel 0, interval 5
      wr(8'h00, 32'hF);
      wr(8'h14, 5); wr(8'h18, 0);
      wr(8'h10, 32'h03);
      idle(8'h1C, 1);
      chk("R4 reload", 64'(bus_rdata), 5);
      idle(8'h1C, 5);
      chk("R6 count at zero", 64'(bus_rdata), 0);
      chk("R6 no early irq", 64'(irq[0]), 0);
      idle(8'h1C, 1);
      chk("R7 reloaded", 64'(bus_rdata), 5);
      chk("R11 irq0 set", 64'(irq[0]), 1);
      wr(8'h04, 32'h0);
      chk("R10 write0 ignored", 64'(irq[0]), 1);
      wr(8'h04, 32'h1);
      chk("R10 write1 clears", 64'(irq[0]), 0);
      wr(8'h10, 32'h00);
      idle(8'h1C, 4);

      // one-shot channel 1, prescale 2
      wr(8'h34, 2); wr(8'h38, 0);
      wr(8'h30, 32'hA3);
      idle(8'h30, 20);
      chk("R8 enable cleared", 64'(bus_rdata), 32'hA0);
      idle(8'h3C, 1);
      chk("R8 count held 0", 64'(bus_rdata), 0);
      idle(8'h04, 1);
      chk("R10 status ch1", 64'(bus_rdata), 2);
      wr(8'h00, 32'hD);
      chk("R11 masked", 64'(irq[1]), 0);
      wr(8'h04, 32'h2);
      wr(8'h00, 32'hF);

      // channel 2: fields, prescale, delayed stop
      wr(8'h54, 10); wr(8'h58, 0);
      wr(8'h50, 32'h13);
      chk("R3 fields", 64'(bus_rdata), 32'h13);
      idle(8'h50, 1);
      chk("R4 reload bit drops", 64'(bus_rdata), 32'h11);
      idle(8'h5C, 3);
      chk("R5 prescale 1", 64'(bus_rdata), 8);
      wr(8'h50, 32'h01);
      idle(8'h5C, 1);
      chk("R5 prescale 0", 64'(bus_rdata), 7);
      wr(8'h50, 32'h00);
      idle(8'h5C, 5);
      chk("R9 two extra ticks", 64'(bus_rdata), 4);

      // channel 3: 64-bit borrow and snapshot
      wr(8'h74, 1); wr(8'h78, 1);
      wr(8'h70, 32'h03);
      idle(8'h7C, 1);
      step(0, 1, 8'h7C, 0);
      idle(8'h80, 1);
      chk("R12 latched high", 64'(bus_rdata), 1);
      step(0, 1, 8'h7C, 0);
      chk("R6 borrow", 64'(bus_rdata), 32'hFFFF_FFFE);
      idle(8'h80, 1);
      chk("R12 relatched", 64'(bus_rdata), 0);
      wr(8'h70, 32'h00);
      idle(8'h08, 1);
      chk("R2 unmapped 08", 64'(bus_rdata), 0);
      idle(8'h0C, 1);
      chk("R2 unmapped 0C", 64'(bus_rdata), 0);
      idle(8'h78, 1);
      chk("R2 ivl high", 64'(bus_rdata), 1);

      // periodic interval 3 with clears colliding with expiries (R10 set wins)
      wr(8'h14, 3);
      wr(8'h10, 32'h03);
      for (int i = 0; i < 16; i++) wr(8'h04, 32'h1);
      idle(8'h1C, 30);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule